// File: doc/BRIEF.md
# Single-Bit Test and Modify Unit

This unit carries out the four single-bit operations of an instruction pipeline on an operand that has already been fetched. It can test a bit, toggle it, clear it or set it. The caller gives the operand value, a bit number, a two-bit operation code and two qualifiers. One qualifier says whether the destination is a 32-bit register or a memory byte. The other says whether the bit number came from a register or from an immediate field. Address generation and bus traffic are handled elsewhere.

On a start strobe the unit registers four things: the modified operand, a write request for the caller, an updated condition-code word and the instruction's cycle count. A one-cycle done pulse qualifies them. Only the zero flag of the condition-code word changes. It reports the state the selected bit had before it was modified. The cycle count depends on three things: the operation, the destination kind and the source of the bit number.

Top module: `bitop_unit`

## Requirements
- R1: Operation code 0 (test) returns the operand unchanged in `result` and never raises `wr_en`.
- R2: Operation code 1 (toggle) inverts exactly the selected bit of the operand and raises `wr_en`.
- R3: Operation code 2 (clear) forces the selected bit to 0, leaves every other bit as it was, and raises `wr_en`.
- R4: Operation code 3 (set) forces the selected bit to 1, leaves every other bit as it was, and raises `wr_en`.
- R5: When `dst_reg` is 1, the bit number is reduced modulo 32, so bit numbers 32 and above wrap onto bits 0 to 31.
- R6: When `dst_reg` is 0, the operand is a byte in bits 7:0. The bit number is reduced modulo 8, and bits 31:8 of `result` equal those of `operand`.
- R7: Bit 2 of `ccr_out` is 1 exactly when the selected bit was 0 before the operation. All other bits of `ccr_out` copy `ccr_in`.
- R8: With `imm_src` = 0, the cycle count is 8 for toggle and set, 4 for test and 8 for clear. Test and clear add 2 when `dst_reg` = 1.
- R9: With `imm_src` = 1, the cycle count is 12 for toggle and set, 8 for test and 12 for clear. Test and clear add 2 when `dst_reg` = 1.
- R10: A start in one cycle gives `done` = 1 with valid results in the next cycle. `done` lasts one cycle unless start repeats. `wr_en` is only ever high together with `done`.
- R11: Synchronous active-high `rst` sets `result`, `wr_en`, `ccr_out`, `cycles` and `done` to zero.
- R12: Between starts, `result`, `ccr_out` and `cycles` hold their last values, while `done` and `wr_en` stay low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture the inputs and perform the operation |
| op_type | input | 2 | 0 test, 1 toggle, 2 clear, 3 set |
| dst_reg | input | 1 | 1: 32-bit register destination; 0: memory byte |
| imm_src | input | 1 | 1: bit number from immediate field; 0: from register |
| bit_num | input | BITNUM_W (8) | Unreduced bit number |
| operand | input | DATA_W (32) | Fetched operand value |
| ccr_in | input | CCR_W (5) | Incoming condition flags, zero flag at bit 2 |
| result | output | DATA_W (32) | Modified operand |
| wr_en | output | 1 | Write the result back (non-test operations) |
| ccr_out | output | CCR_W (5) | Outgoing condition flags |
| cycles | output | CYC_W (5) | Instruction cycle count |
| done | output | 1 | One-cycle result qualifier |

## Verification
The bench builds the unit with its default parameters: a 32-bit data width, an 8-bit byte lane and an 8-bit bit-number input. Bit numbers up to 255 can therefore be driven. This reaches the wrap in both the modulo-32 and the modulo-8 reductions, and it shows whether a byte operation ever disturbs bits 31:8. Every operation is run with both destination kinds and both bit-number sources, so all twelve cycle-count cases are covered. Starts are issued back to back as well as spaced apart, which tests that each result stays paired with its own start.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

  typedef enum logic [1:0] {
    BOP_TEST = 2'd0,
    BOP_FLIP = 2'd1,
    BOP_CLR  = 2'd2,
    BOP_SET  = 2'd3
  } bop_e;

  localparam int CYC_W_PKG = 5;

  // Cycle cost: bit-number source, operation class, register surcharge
  function automatic logic [CYC_W_PKG-1:0] bop_cost(bop_e op, logic dst_reg, logic imm_src);
    logic [CYC_W_PKG-1:0] c;
    case (op)
      BOP_TEST: c = imm_src ? CYC_W_PKG'(8)  : CYC_W_PKG'(4);
      BOP_CLR:  c = imm_src ? CYC_W_PKG'(12) : CYC_W_PKG'(8);
      default:  c = imm_src ? CYC_W_PKG'(12) : CYC_W_PKG'(8);
    endcase
    if (dst_reg && (op == BOP_TEST || op == BOP_CLR))
      c = c + CYC_W_PKG'(2);
    return c;
  endfunction

endpackage

// File: rtl/bitop_index.sv
module bitop_index #(
  parameter int DATA_W   = 32,
  parameter int BYTE_W   = 8,
  parameter int BITNUM_W = 8
) (
  input  logic [BITNUM_W-1:0] bit_num,
  input  logic                dst_reg,
  output logic [DATA_W-1:0]   sel_mask
);
  localparam int REG_IDX_W = $clog2(DATA_W);
  localparam int MEM_IDX_W = $clog2(BYTE_W);

  logic [REG_IDX_W-1:0] idx;

  always_comb begin
    if (dst_reg) idx = bit_num[REG_IDX_W-1:0];
    else         idx = REG_IDX_W'(bit_num[MEM_IDX_W-1:0]);
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    if (i < BYTE_W) begin : g_low
      assign sel_mask[i] = (idx == REG_IDX_W'(i));
    end else begin : g_high
      assign sel_mask[i] = dst_reg && (idx == REG_IDX_W'(i));
    end
  end
endmodule

// File: rtl/bitop_alu.sv
module bitop_alu
  import bitop_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  bop_e              op,
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W-1:0] sel_mask,
  output logic [DATA_W-1:0] mod_word,
  output logic              pre_bit,
  output logic              wr_req
);
  assign pre_bit = |(operand & sel_mask);
  assign wr_req  = (op != BOP_TEST);

  always_comb begin
    case (op)
      BOP_FLIP: mod_word = operand ^ sel_mask;
      BOP_CLR:  mod_word = operand & ~sel_mask;
      BOP_SET:  mod_word = operand | sel_mask;
      default:  mod_word = operand;
    endcase
  end
endmodule

// File: rtl/bitop_timing.sv
module bitop_timing
  import bitop_pkg::*;
#(
  parameter int CYC_W = 5
) (
  input  bop_e             op,
  input  logic             dst_reg,
  input  logic             imm_src,
  output logic [CYC_W-1:0] cyc_next
);
  assign cyc_next = CYC_W'(bop_cost(op, dst_reg, imm_src));
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bitop_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int BYTE_W   = 8,
  parameter int BITNUM_W = 8,
  parameter int CCR_W    = 5,
  parameter int ZF_POS   = 2,
  parameter int CYC_W    = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [1:0]          op_type,
  input  logic                dst_reg,
  input  logic                imm_src,
  input  logic [BITNUM_W-1:0] bit_num,
  input  logic [DATA_W-1:0]   operand,
  input  logic [CCR_W-1:0]    ccr_in,
  output logic [DATA_W-1:0]   result,
  output logic                wr_en,
  output logic [CCR_W-1:0]    ccr_out,
  output logic [CYC_W-1:0]    cycles,
  output logic                done
);
  bop_e              op;
  logic [DATA_W-1:0] sel_mask;
  logic [DATA_W-1:0] mod_word;
  logic              pre_bit;
  logic              wr_req;
  logic [CYC_W-1:0]  cyc_next;
  logic [CCR_W-1:0]  ccr_next;

  assign op = bop_e'(op_type);

  bitop_index #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .BITNUM_W(BITNUM_W)) u_index (
    .bit_num (bit_num),
    .dst_reg (dst_reg),
    .sel_mask(sel_mask)
  );

  bitop_alu #(.DATA_W(DATA_W)) u_alu (
    .op      (op),
    .operand (operand),
    .sel_mask(sel_mask),
    .mod_word(mod_word),
    .pre_bit (pre_bit),
    .wr_req  (wr_req)
  );

  bitop_timing #(.CYC_W(CYC_W)) u_timing (
    .op      (op),
    .dst_reg (dst_reg),
    .imm_src (imm_src),
    .cyc_next(cyc_next)
  );

  always_comb begin
    ccr_next         = ccr_in;
    ccr_next[ZF_POS] = ~pre_bit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result  <= '0;
      wr_en   <= 1'b0;
      ccr_out <= '0;
      cycles  <= '0;
      done    <= 1'b0;
    end else begin
      done  <= start;
      wr_en <= start && wr_req;
      if (start) begin
        result  <= mod_word;
        ccr_out <= ccr_next;
        cycles  <= cyc_next;
      end
    end
  end
endmodule

// File: rtl/bitop_unit_chk.sv
module bitop_unit_chk #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int CCR_W  = 5,
  parameter int ZF_POS = 2,
  parameter int CYC_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [1:0]        op_type,
  input logic              dst_reg,
  input logic [DATA_W-1:0] operand,
  input logic [CCR_W-1:0]  ccr_in,
  input logic [DATA_W-1:0] sel_mask,
  input logic [DATA_W-1:0] result,
  input logic              wr_en,
  input logic [CCR_W-1:0]  ccr_out,
  input logic [CYC_W-1:0]  cycles,
  input logic              done
);
  // R5/R6: exactly one bit is selected for any start
  assert_one_bit_R5: assert property (@(posedge clk) disable iff (rst)
    start |-> ($countones(sel_mask) == 1));

  // R10: done follows start by one cycle
  assert_done_follows_R10: assert property (@(posedge clk) disable iff (rst)
    start |=> done);
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    !start |=> !done);
  assert_wr_qualified_R10: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> done);

  // R1: test never writes
  assert_test_no_write_R1: assert property (@(posedge clk) disable iff (rst)
    (start && op_type == 2'd0) |=> (!wr_en && result == $past(operand)));

  // R2: toggle changes exactly one bit
  assert_toggle_one_R2: assert property (@(posedge clk) disable iff (rst)
    (start && op_type == 2'd1) |=> (wr_en && $countones(result ^ $past(operand)) == 1));

  // R6: byte operations keep the upper bits
  assert_byte_upper_R6: assert property (@(posedge clk) disable iff (rst)
    (start && !dst_reg) |=> (result[DATA_W-1:BYTE_W] == $past(operand[DATA_W-1:BYTE_W])));

  // R7: only the zero flag may differ from the incoming flags
  assert_flags_pass_R7: assert property (@(posedge clk) disable iff (rst)
    start |=> ((ccr_out ^ $past(ccr_in)) & ~(CCR_W'(1) << ZF_POS)) == '0);

  // R8/R9: the count is even and between 4 and 14
  assert_cycles_range_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> (!cycles[0] && cycles >= CYC_W'(4) && cycles <= CYC_W'(14)));

  // R12: results hold while idle
  assert_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> ($stable(result) && $stable(ccr_out) && $stable(cycles)));
endmodule

bind bitop_unit bitop_unit_chk #(
  .DATA_W(DATA_W), .BYTE_W(BYTE_W), .CCR_W(CCR_W), .ZF_POS(ZF_POS), .CYC_W(CYC_W)
) u_chk (
  .clk(clk), .rst(rst), .start(start), .op_type(op_type), .dst_reg(dst_reg),
  .operand(operand), .ccr_in(ccr_in), .sel_mask(sel_mask), .result(result),
  .wr_en(wr_en), .ccr_out(ccr_out), .cycles(cycles), .done(done)
);

// File: tb/bitop_unit_tb.sv
module bitop_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  op_type = '0;
  logic        dst_reg = 1'b0;
  logic        imm_src = 1'b0;
  logic [7:0]  bit_num = '0;
  logic [31:0] operand = '0;
  logic [4:0]  ccr_in = '0;
  logic [31:0] result;
  logic        wr_en;
  logic [4:0]  ccr_out;
  logic [4:0]  cycles;
  logic        done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct {
    logic [31:0] res;
    logic        we;
    logic [4:0]  ccr;
    logic [4:0]  cyc;
    string       tag;
  } exp_t;

  exp_t sb[$];

  always #2 clk = ~clk;

  bitop_unit u_dut (
    .clk(clk), .rst(rst), .start(start), .op_type(op_type), .dst_reg(dst_reg),
    .imm_src(imm_src), .bit_num(bit_num), .operand(operand), .ccr_in(ccr_in),
    .result(result), .wr_en(wr_en), .ccr_out(ccr_out), .cycles(cycles), .done(done)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Bench model: bit position, then per-operation outcome
  function automatic exp_t model(input logic [1:0] op, input logic dreg, input logic imm,
                                 input logic [7:0] bn, input logic [31:0] d, input logic [4:0] f,
                                 input string tag);
    exp_t e;
    int pos;
    logic old;
    pos = dreg ? (bn % 32) : (bn % 8);
    old = d[pos];
    e.res = d;
    if (op == 2'd1) e.res[pos] = ~old;
    if (op == 2'd2) e.res[pos] = 1'b0;
    if (op == 2'd3) e.res[pos] = 1'b1;
    e.we = (op != 2'd0);
    e.ccr = f;
    e.ccr[2] = (old == 1'b0);
    e.cyc = 5'((imm ? 4 : 0) + (op == 2'd0 ? 4 : 8) + ((dreg && !op[0]) ? 2 : 0));
    e.tag = tag;
    return e;
  endfunction

  task automatic issue(input logic [1:0] op, input logic dreg, input logic imm,
                       input logic [7:0] bn, input logic [31:0] d, input logic [4:0] f,
                       input string tag);
    @(negedge clk);
    op_type = op; dst_reg = dreg; imm_src = imm; bit_num = bn; operand = d; ccr_in = f;
    start = 1'b1;
    sb.push_back(model(op, dreg, imm, bn, d, f, tag));
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    start = 1'b0;
    repeat (n - 1) @(negedge clk);
  endtask

  // Monitor: compare against the oldest expected item when done appears
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (!rst) begin
        if (done) begin
          if (sb.size() == 0) begin
            check(1'b0, "R10 unexpected done", 32'(done), 32'd0);
          end else begin
            exp_t e;
            e = sb.pop_front();
            check(result == e.res, {e.tag, " result"}, result, e.res);
            check(wr_en == e.we, {e.tag, " R10 wr_en"}, 32'(wr_en), 32'(e.we));
            check(ccr_out == e.ccr, {e.tag, " R7 ccr"}, 32'(ccr_out), 32'(e.ccr));
            check(cycles == e.cyc, {e.tag, " R8/R9 cycles"}, 32'(cycles), 32'(e.cyc));
          end
        end else begin
          if (wr_en) check(1'b0, "R10 wr_en without done", 32'(wr_en), 32'd0);
        end
      end
    end
  end

  task automatic check_reset_state(input string tag);
    check(result == 32'd0, {tag, " R11 result"}, result, 32'd0);
    check(ccr_out == 5'd0 && cycles == 5'd0, {tag, " R11 ccr/cycles"},
          {22'd0, ccr_out, cycles}, 32'd0);
    check(!done && !wr_en, {tag, " R11 done/wr_en"}, {30'd0, done, wr_en}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_reset_state("init");
    rst = 1'b0;

    // R1 test on register and memory, both sources
    issue(2'd0, 1'b1, 1'b0, 8'd5,  32'h0000_0020, 5'h1B, "R1 test reg set-bit");
    issue(2'd0, 1'b0, 1'b1, 8'd3,  32'hFFFF_FFF7, 5'h04, "R1 test mem clear-bit");
    issue(2'd0, 1'b1, 1'b1, 8'd31, 32'h8000_0000, 5'h00, "R1 test reg msb");
    issue(2'd0, 1'b0, 1'b0, 8'd0,  32'h0000_0000, 5'h1F, "R1 test mem b0");
    // R2 toggle
    issue(2'd1, 1'b1, 1'b0, 8'd17, 32'h1234_5678, 5'h0A, "R2 toggle reg");
    issue(2'd1, 1'b0, 1'b1, 8'd6,  32'hDEAD_BE00, 5'h11, "R2 toggle mem");
    issue(2'd1, 1'b1, 1'b1, 8'd0,  32'hFFFF_FFFF, 5'h15, "R2 toggle reg b0");
    issue(2'd1, 1'b0, 1'b0, 8'd7,  32'h0000_0080, 5'h00, "R2 toggle mem b7");
    idle(2);
    // R3 clear
    issue(2'd2, 1'b1, 1'b0, 8'd12, 32'hFFFF_FFFF, 5'h04, "R3 clear reg");
    issue(2'd2, 1'b0, 1'b1, 8'd2,  32'h0000_0000, 5'h1B, "R3 clear mem already0");
    issue(2'd2, 1'b1, 1'b1, 8'd30, 32'h4000_0001, 5'h0E, "R3 clear reg b30");
    issue(2'd2, 1'b0, 1'b0, 8'd4,  32'hAAAA_AA10, 5'h01, "R3 clear mem");
    // R4 set
    issue(2'd3, 1'b1, 1'b0, 8'd9,  32'h0000_0000, 5'h1F, "R4 set reg");
    issue(2'd3, 1'b0, 1'b1, 8'd1,  32'h5555_5502, 5'h00, "R4 set mem already1");
    issue(2'd3, 1'b1, 1'b1, 8'd31, 32'h7FFF_FFFF, 5'h13, "R4 set reg msb");
    issue(2'd3, 1'b0, 1'b0, 8'd5,  32'hFFFF_FF00, 5'h08, "R4 set mem");
    idle(3);
    // R5 register wrap modulo 32
    issue(2'd1, 1'b1, 1'b0, 8'd32,  32'h0000_0000, 5'h00, "R5 wrap 32->0");
    issue(2'd3, 1'b1, 1'b1, 8'd63,  32'h0000_0000, 5'h00, "R5 wrap 63->31");
    issue(2'd2, 1'b1, 1'b0, 8'd200, 32'hFFFF_FFFF, 5'h00, "R5 wrap 200->8");
    // R6 memory wrap modulo 8, upper bits untouched
    issue(2'd3, 1'b0, 1'b0, 8'd13,  32'hA5A5_5A00, 5'h00, "R6 wrap 13->5");
    issue(2'd1, 1'b0, 1'b1, 8'd255, 32'hFFFF_FF7F, 5'h00, "R6 wrap 255->7");
    issue(2'd2, 1'b0, 1'b0, 8'd24,  32'hFFFF_FFFF, 5'h1F, "R6 wrap 24->0");
    idle(3);

    // R8/R9 every operation, destination and source combination
    for (int op = 0; op < 4; op++)
      for (int k = 0; k < 4; k++)
        issue(2'(op), k[0], k[1], 8'(op * 7 + k), 32'hC3C3_3C3C, 5'(op + k), "R8/R9 sweep");
    idle(3);

    // R12 hold after a result while idle
    issue(2'd3, 1'b1, 1'b1, 8'd20, 32'h0000_0000, 5'h15, "R12 setup");
    idle(2);
    begin
      logic [31:0] r0;
      logic [4:0]  c0, y0;
      r0 = result; c0 = ccr_out; y0 = cycles;
      repeat (4) @(negedge clk);
      check(result == r0 && ccr_out == c0 && cycles == y0, "R12 hold values", result, r0);
      check(!done && !wr_en, "R12 idle strobes", {30'd0, done, wr_en}, 32'd0);
    end

    // R11 reset after activity
    issue(2'd1, 1'b1, 1'b0, 8'd3, 32'h0000_00FF, 5'h1F, "R11 pre-reset");
    idle(2);
    rst = 1'b1;
    @(negedge clk);
    check_reset_state("mid");
    rst = 1'b0;
    idle(2);
    check(sb.size() == 0, "R10 scoreboard drained", 32'(sb.size()), 32'd0);

    if (!finished) begin
      finished = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog R10 actual=timeout expected=completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule